// File: doc/BRIEF.md
# Prefetch Request Decode and Issue

This block sits in the second-level cache controller and handles one software prefetch at a time. It takes the prefetch's 5-bit function code and its line address. The function code selects one of four outcomes: a no-op, an illegal-instruction trap, a prefetch for reading, or a prefetch for writing. For the two prefetch kinds, the block asks the shared cache lookup port for the line. It then judges the hit flag and coherence state that come back. Read prefetches test only whether the line is present. Write prefetches also need the line to be held in an owned state.

When the lookup shows a miss, the block waits for the outstanding-miss tracker to report a free slot. It then issues a shared-read or an ownership-read request to the system side and waits for the fill. The returned line is written into the second-level cache only. Nothing is written to the first-level data cache or returned to a register. Every accepted prefetch ends with a single-cycle completion pulse.

Load and store lookups always take the cache lookup port ahead of the prefetch. A prefetch that is waiting for a slot or for a fill does not hold the port, so later load and store hits pass through freely.

The controller is a single state machine with eight states:

| State | Role |
|-------|------|
| `ST_IDLE` | Ready to accept a prefetch. |
| `ST_LOOK` | Asks for the lookup port. |
| `ST_RESP` | Samples the lookup result. |
| `ST_ISSUE` | Waits for a free slot. |
| `ST_FILL` | Waits for fill data. |
| `ST_WRITE` | Writes the second-level cache. |
| `ST_TRAP` | Signals the trap and completion. |
| `ST_DONE` | Signals completion. |

It has these transitions:

| Transition | From | To | Condition |
|------------|------|----|-----------|
| T_ACC_NOP | IDLE | DONE | No-op code accepted. |
| T_ACC_TRAP | IDLE | TRAP | Reserved code accepted. |
| T_ACC_PF | IDLE | LOOK | Read or write code accepted. |
| T_GRANT | LOOK | RESP | Lookup port granted. |
| T_HIT | RESP | DONE | No request needed. |
| T_MISS | RESP | ISSUE | Request needed. |
| T_SLOT | ISSUE | FILL | Slot free; request issued. |
| T_FILLED | FILL | WRITE | Fill data arrives. |
| T_WROTE | WRITE | DONE | Cache written. |
| T_TRAP_END | TRAP | IDLE | Always. |
| T_END | DONE | IDLE | Always. |

Top module: `pf_issue`

## Requirements
- R1: After reset, `pf_ready` is 1 and `pf_done`, `pf_trap`, `req_valid`, `l2_wr_en` and `cl_src_pf` are all 0.
- R2: Codes 0, 1 and 4 are read prefetches. When `lk_hit`=0 they issue one request with `req_own`=0. When `lk_hit`=1 they issue none.
- R3: Codes 2 and 3 are write prefetches. `lk_state` is encoded I=0, S=1, E=2, M=3. These codes issue one request with `req_own`=1 unless `lk_hit`=1 and `lk_state` is 2 or 3.
- R4: Codes 5 to 15 make no lookup and no request. They raise `pf_trap` together with `pf_done` in the cycle after acceptance.
- R5: Codes 16 to 31 make no lookup, no request and no trap. They raise `pf_done` in the cycle after acceptance.
- R6: A prefetch that needs no request raises `pf_done` two cycles after its lookup is granted, with no system request.
- R7: `req_valid` is a single-cycle pulse carrying the prefetch's address on `req_addr`. It is raised only while `slot_free` is 1, in the first such cycle starting two cycles after the lookup grant.
- R8: `fill_valid` while the block awaits a fill causes exactly one `l2_wr_en` pulse in the next cycle, with the fill data and the prefetch address. `pf_done` follows in the cycle after that.
- R9: Whenever `ls_req` is 1, the lookup port serves the load/store in that same cycle: `cl_req`=1, `cl_src_pf`=0, `cl_addr`=`ls_addr`. This holds while a prefetch waits for a slot or a fill. A prefetch lookup is deferred until `ls_req` is 0 and is made exactly once.
- R10: Each accepted prefetch gives exactly one single-cycle `pf_done` pulse. `pf_ready` is 0 from acceptance until the cycle after `pf_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 1 | Prefetch offered |
| pf_fcn | input | 5 | Prefetch function code |
| pf_addr | input | AW | Prefetch line address |
| pf_ready | output | 1 | Block idle, accepts a prefetch |
| ls_req | input | 1 | Load/store lookup request |
| ls_addr | input | AW | Load/store lookup address |
| cl_req | output | 1 | Cache lookup request |
| cl_addr | output | AW | Cache lookup address |
| cl_src_pf | output | 1 | Lookup this cycle belongs to the prefetch |
| lk_hit | input | 1 | Lookup hit flag, valid the cycle after a prefetch grant |
| lk_state | input | 2 | Line coherence state (I=0, S=1, E=2, M=3) |
| slot_free | input | 1 | Outstanding-miss tracker has a free slot |
| req_valid | output | 1 | System read request pulse |
| req_own | output | 1 | 1 = ownership read, 0 = shared read |
| req_addr | output | AW | Request line address |
| fill_valid | input | 1 | Fill data returned |
| fill_data | input | DW | Returned line data |
| l2_wr_en | output | 1 | Second-level cache write strobe |
| l2_wr_addr | output | AW | Second-level cache write address |
| l2_wr_data | output | DW | Second-level cache write data |
| pf_done | output | 1 | Prefetch completion pulse |
| pf_trap | output | 1 | Illegal-instruction trap pulse |

## Verification
Every output is a decode of the state register, so each result is due at a fixed cycle count after the edge that caused it. No-op and trap completions come one cycle after acceptance. A hit completes two cycles after the lookup grant. A request comes two cycles after the grant, or later if `slot_free` is held low. The cache write comes one cycle after `fill_valid`, and completion one cycle after the write. The bench numbers each cycle after acceptance. It drives inputs at the falling edge and samples outputs just after. It records the cycle number at which each pulse appeared and compares that with the number it derives from the same counts. This is done over every function code, both hit values, every coherence state, and both with and without load/store contention and slot delay.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    // Coherence state of a second-level line as reported by the lookup.
    typedef enum logic [1:0] {
        COH_I = 2'd0,
        COH_S = 2'd1,
        COH_E = 2'd2,
        COH_M = 2'd3
    } coh_e;

    // Class of a prefetch after decoding its function code.
    typedef enum logic [1:0] {
        PK_NOP  = 2'd0,
        PK_TRAP = 2'd1,
        PK_RD   = 2'd2,
        PK_WR   = 2'd3
    } pk_e;

    // Controller states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOOK  = 3'd1,
        ST_RESP  = 3'd2,
        ST_ISSUE = 3'd3,
        ST_FILL  = 3'd4,
        ST_WRITE = 3'd5,
        ST_TRAP  = 3'd6,
        ST_DONE  = 3'd7
    } st_e;

endpackage

// File: rtl/pfq_decode.sv
module pfq_decode
    import pfq_pkg::*;
#(
    parameter int FW = 5
) (
    input  logic [FW-1:0] fcn,
    output pk_e           kind
);
    // Boundaries of the code ranges; upper half of the code space is no-op.
    localparam int TRAP_LO = 5;
    localparam int TRAP_HI = 15;
    localparam int NOP_LO  = 1 << (FW - 1);

    always_comb begin
        kind = PK_NOP;
        if (int'(fcn) >= NOP_LO) begin
            kind = PK_NOP;
        end else if (int'(fcn) >= TRAP_LO && int'(fcn) <= TRAP_HI) begin
            kind = PK_TRAP;
        end else if (fcn == FW'(2) || fcn == FW'(3)) begin
            kind = PK_WR;
        end else if (fcn == FW'(0) || fcn == FW'(1) || fcn == FW'(4)) begin
            kind = PK_RD;
        end else begin
            kind = PK_NOP;
        end
    end

endmodule

// File: rtl/pfq_miss_eval.sv
module pfq_miss_eval
    import pfq_pkg::*;
(
    input  pk_e        kind,
    input  logic       hit,
    input  logic [1:0] coh,
    output logic       need_req,
    output logic       own
);
    logic owned;

    always_comb begin
        owned    = hit && (coh == COH_E || coh == COH_M);
        need_req = 1'b0;
        own      = 1'b0;
        unique case (kind)
            PK_RD: begin
                need_req = !hit;
                own      = 1'b0;
            end
            PK_WR: begin
                need_req = !owned;
                own      = 1'b1;
            end
            PK_NOP, PK_TRAP: begin
                need_req = 1'b0;
                own      = 1'b0;
            end
            default: begin
                need_req = 1'b0;
                own      = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pfq_lookup_arb.sv
module pfq_lookup_arb #(
    parameter int AW = 16
) (
    input  logic          ls_req,
    input  logic [AW-1:0] ls_addr,
    input  logic          pf_want,
    input  logic [AW-1:0] pf_addr,
    output logic          cl_req,
    output logic [AW-1:0] cl_addr,
    output logic          cl_src_pf,
    output logic          pf_grant
);
    // Loads and stores always win; the prefetch only fills idle slots.
    always_comb begin
        pf_grant  = pf_want && !ls_req;
        cl_req    = ls_req || pf_want;
        cl_src_pf = pf_grant;
        cl_addr   = ls_req ? ls_addr : pf_addr;
    end

endmodule

// File: rtl/pf_issue.sv
module pf_issue
    import pfq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pf_valid,
    input  logic [FW-1:0] pf_fcn,
    input  logic [AW-1:0] pf_addr,
    output logic          pf_ready,
    input  logic          ls_req,
    input  logic [AW-1:0] ls_addr,
    output logic          cl_req,
    output logic [AW-1:0] cl_addr,
    output logic          cl_src_pf,
    input  logic          lk_hit,
    input  logic [1:0]    lk_state,
    input  logic          slot_free,
    output logic          req_valid,
    output logic          req_own,
    output logic [AW-1:0] req_addr,
    input  logic          fill_valid,
    input  logic [DW-1:0] fill_data,
    output logic          l2_wr_en,
    output logic [AW-1:0] l2_wr_addr,
    output logic [DW-1:0] l2_wr_data,
    output logic          pf_done,
    output logic          pf_trap
);

    st_e           state_q, state_d;
    pk_e           kind_in, kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          own_q;
    logic          need_w, own_w;
    logic          pf_want, pf_grant;

    pfq_decode #(.FW(FW)) u_dec (
        .fcn  (pf_fcn),
        .kind (kind_in)
    );

    pfq_miss_eval u_eval (
        .kind     (kind_q),
        .hit      (lk_hit),
        .coh      (lk_state),
        .need_req (need_w),
        .own      (own_w)
    );

    pfq_lookup_arb #(.AW(AW)) u_arb (
        .ls_req    (ls_req),
        .ls_addr   (ls_addr),
        .pf_want   (pf_want),
        .pf_addr   (addr_q),
        .cl_req    (cl_req),
        .cl_addr   (cl_addr),
        .cl_src_pf (cl_src_pf),
        .pf_grant  (pf_grant)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Per-prefetch context: class, address, request type, fill data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= PK_NOP;
            addr_q <= '0;
            own_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && pf_valid) begin
                kind_q <= kind_in;
                addr_q <= pf_addr;
            end
            if (state_q == ST_RESP) begin
                own_q <= own_w;
            end
            if (state_q == ST_FILL && fill_valid) begin
                data_q <= fill_data;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pf_valid) begin
                    unique case (kind_in)
                        PK_NOP:  state_d = ST_DONE;
                        PK_TRAP: state_d = ST_TRAP;
                        PK_RD,
                        PK_WR:   state_d = ST_LOOK;
                        default: state_d = ST_DONE;
                    endcase
                end
            end
            ST_LOOK:  if (pf_grant) state_d = ST_RESP;
            ST_RESP:  state_d = need_w ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (slot_free) state_d = ST_FILL;
            ST_FILL:  if (fill_valid) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            ST_TRAP:  state_d = ST_IDLE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state register.
    always_comb begin
        pf_ready   = 1'b0;
        pf_want    = 1'b0;
        req_valid  = 1'b0;
        l2_wr_en   = 1'b0;
        pf_done    = 1'b0;
        pf_trap    = 1'b0;
        req_own    = own_q;
        req_addr   = addr_q;
        l2_wr_addr = addr_q;
        l2_wr_data = data_q;
        unique case (state_q)
            ST_IDLE:  pf_ready  = 1'b1;
            ST_LOOK:  pf_want   = 1'b1;
            ST_RESP:  ;
            ST_ISSUE: req_valid = slot_free;
            ST_FILL:  ;
            ST_WRITE: l2_wr_en  = 1'b1;
            ST_TRAP: begin
                pf_trap = 1'b1;
                pf_done = 1'b1;
            end
            ST_DONE:  pf_done   = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/pf_issue_chk.sv
module pf_issue_chk #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pf_ready,
    input logic          ls_req,
    input logic [AW-1:0] ls_addr,
    input logic          cl_req,
    input logic [AW-1:0] cl_addr,
    input logic          cl_src_pf,
    input logic          slot_free,
    input logic          req_valid,
    input logic          fill_valid,
    input logic [DW-1:0] fill_data,
    input logic          l2_wr_en,
    input logic [DW-1:0] l2_wr_data,
    input logic          pf_done,
    input logic          pf_trap
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pf_ready |-> (!pf_done && !req_valid && !l2_wr_en && !cl_src_pf)); // R1

    AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_trap |-> (pf_done && !req_valid && !cl_src_pf)); // R4

    AST_REQ_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> slot_free); // R7

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R7

    AST_WR_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        l2_wr_en |-> ($past(fill_valid) && l2_wr_data == $past(fill_data))); // R8

    AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        l2_wr_en |=> pf_done); // R8

    AST_LS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ls_req |-> (cl_req && !cl_src_pf && cl_addr == ls_addr)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_done |=> (!pf_done && pf_ready)); // R10

endmodule

bind pf_issue pf_issue_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pf_ready   (pf_ready),
    .ls_req     (ls_req),
    .ls_addr    (ls_addr),
    .cl_req     (cl_req),
    .cl_addr    (cl_addr),
    .cl_src_pf  (cl_src_pf),
    .slot_free  (slot_free),
    .req_valid  (req_valid),
    .fill_valid (fill_valid),
    .fill_data  (fill_data),
    .l2_wr_en   (l2_wr_en),
    .l2_wr_data (l2_wr_data),
    .pf_done    (pf_done),
    .pf_trap    (pf_trap)
);

// File: tb/pf_issue_tb.sv
module pf_issue_tb;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pf_valid = 1'b0;
    logic [4:0]    pf_fcn = '0;
    logic [AW-1:0] pf_addr = '0;
    logic          pf_ready;
    logic          ls_req = 1'b0;
    logic [AW-1:0] ls_addr = '0;
    logic          cl_req;
    logic [AW-1:0] cl_addr;
    logic          cl_src_pf;
    logic          lk_hit = 1'b0;
    logic [1:0]    lk_state = '0;
    logic          slot_free = 1'b1;
    logic          req_valid;
    logic          req_own;
    logic [AW-1:0] req_addr;
    logic          fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;
    logic          l2_wr_en;
    logic [AW-1:0] l2_wr_addr;
    logic [DW-1:0] l2_wr_data;
    logic          pf_done;
    logic          pf_trap;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    pf_issue #(.AW(AW), .DW(DW), .FW(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_fcn(pf_fcn),
        .pf_addr(pf_addr), .pf_ready(pf_ready), .ls_req(ls_req),
        .ls_addr(ls_addr), .cl_req(cl_req), .cl_addr(cl_addr),
        .cl_src_pf(cl_src_pf), .lk_hit(lk_hit), .lk_state(lk_state),
        .slot_free(slot_free), .req_valid(req_valid), .req_own(req_own),
        .req_addr(req_addr), .fill_valid(fill_valid), .fill_data(fill_data),
        .l2_wr_en(l2_wr_en), .l2_wr_addr(l2_wr_addr), .l2_wr_data(l2_wr_data),
        .pf_done(pf_done), .pf_trap(pf_trap)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // One prefetch from offer to completion, with a cycle-numbered monitor.
    task automatic run_pf(input int fcn, input bit hit, input int st,
                          input bit ls_stall, input bit slot_delay);
        int  kind;          // 0 nop, 1 trap, 2 read, 3 write
        bit  need, own_exp;
        int  g, r_exp, done_exp, wr_exp;
        int  n_done, n_trap, n_req, n_wr, n_look;
        int  done_at, req_at, wr_at;
        logic          own_seen;
        logic [AW-1:0] raddr_seen, waddr_seen;
        logic [DW-1:0] wdata_seen;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        bit  ls_ok;

        if (fcn >= 16)                 kind = 0;
        else if (fcn >= 5)             kind = 1;
        else if (fcn == 2 || fcn == 3) kind = 3;
        else                           kind = 2;
        need    = (kind == 2) ? !hit : (kind == 3) ? !(hit && st >= 2) : 1'b0;
        own_exp = (kind == 3);
        g       = ls_stall ? 3 : 1;
        r_exp   = (slot_delay && g + 2 < 5) ? 5 : g + 2;
        wr_exp  = r_exp + 4;
        if (kind < 2)   done_exp = 1;
        else if (!need) done_exp = g + 2;
        else            done_exp = wr_exp + 1;

        a = AW'(16'h1000 + fcn * 37 + st * 5 + int'(hit) * 3);
        d = DW'(32'hA5000000 + fcn * 257 + st * 17 + int'(hit));
        n_done = 0; n_trap = 0; n_req = 0; n_wr = 0; n_look = 0;
        done_at = -1; req_at = -1; wr_at = -1;
        own_seen = 1'b0; raddr_seen = '0; waddr_seen = '0; wdata_seen = '0;
        ls_ok = 1'b1;

        @(negedge clk);
        lk_hit    = hit;
        lk_state  = 2'(st);
        slot_free = !slot_delay;
        pf_valid  = 1'b1;
        pf_fcn    = 5'(fcn);
        pf_addr   = a;
        for (int n = 1; n <= 24; n++) begin
            @(negedge clk);
            pf_valid   = 1'b0;
            ls_req     = 1'b0;
            fill_valid = 1'b0;
            if (ls_stall && n <= 2) begin
                ls_req  = 1'b1;
                ls_addr = AW'(16'h7000 + n);
            end
            if (req_at > 0 && (n == req_at + 1 || n == req_at + 2)) begin
                ls_req  = 1'b1;
                ls_addr = AW'(16'h7100 + n);
            end
            if (n >= 5) slot_free = 1'b1;
            if (req_at > 0 && n == req_at + 3) begin
                fill_valid = 1'b1;
                fill_data  = d;
            end
            #1;
            if (n == 1) chk(pf_ready == 1'b0, "R10 busy after accept", pf_ready, 0);
            if (ls_req && !(cl_req && !cl_src_pf && cl_addr == ls_addr)) ls_ok = 1'b0;
            if (cl_src_pf) begin
                n_look++;
                if (cl_addr != a) ls_ok = 1'b0;
            end
            if (pf_done) begin n_done++; if (done_at < 0) done_at = n; end
            if (pf_trap) n_trap++;
            if (req_valid) begin
                n_req++;
                if (req_at < 0) req_at = n;
                own_seen = req_own; raddr_seen = req_addr;
            end
            if (l2_wr_en) begin
                n_wr++; wr_at = n;
                waddr_seen = l2_wr_addr; wdata_seen = l2_wr_data;
            end
        end

        chk(n_done == 1, "R10 one done", n_done, 1);
        chk(done_at == done_exp,
            (kind == 1) ? "R4 done cycle" : (kind == 0) ? "R5 done cycle" :
            need ? "R8 done cycle" : "R6 done cycle", done_at, done_exp);
        chk(n_trap == (kind == 1 ? 1 : 0), "R4 trap count", n_trap, kind == 1 ? 1 : 0);
        chk(n_look == (kind >= 2 ? 1 : 0), "R9 prefetch lookups", n_look, kind >= 2 ? 1 : 0);
        chk(ls_ok, "R9 load/store priority", ls_ok, 1);
        if (kind == 3) chk(n_req == int'(need), "R3 request count", n_req, int'(need));
        else if (kind == 2) chk(n_req == int'(need), "R2 request count", n_req, int'(need));
        else chk(n_req == 0, "R5 no request", n_req, 0);
        if (need) begin
            chk(own_seen == own_exp, own_exp ? "R3 ownership type" : "R2 shared type",
                own_seen, own_exp);
            chk(req_at == r_exp, "R7 request cycle", req_at, r_exp);
            chk(raddr_seen == a, "R7 request address", raddr_seen, a);
            chk(n_wr == 1 && wr_at == wr_exp, "R8 write cycle", wr_at, wr_exp);
            chk(wdata_seen == d, "R8 write data", wdata_seen, d);
            chk(waddr_seen == a, "R8 write address", waddr_seen, a);
        end else begin
            chk(n_wr == 0, "R6 no cache write", n_wr, 0);
        end
        chk(pf_ready == 1'b1, "R10 ready at end", pf_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(pf_ready == 1'b1, "R1 ready in reset", pf_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(pf_ready == 1'b1, "R1 ready", pf_ready, 1);
        chk(!pf_done && !pf_trap, "R1 no pulses", {pf_done, pf_trap}, 0);
        chk(!req_valid && !l2_wr_en, "R1 no request or write", {req_valid, l2_wr_en}, 0);
        chk(!cl_src_pf, "R1 no prefetch lookup", cl_src_pf, 0);
        for (int f = 0; f < 32; f++) begin
            for (int h = 0; h < 2; h++) begin
                for (int s = 0; s < 4; s++) begin
                    run_pf(f, h[0], s, bit'((f ^ s) & 1), bit'((s >> 1) ^ h));
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule